// File: doc/BRIEF.md
# Cascaded Four-Bit One-Cold Decoder

The block turns a 4-bit select value into sixteen active-low lines. At most one line is driven low at any time. It is built from two identical 3-bit slices. Each slice drives eight active-low lines and has three enable terms: one that is active high and two that are active low. A slice drives a line low only when all three enable terms are asserted.

The top level joins two slices through their enable terms alone. The top select bit enables the lower slice when it is 0 and the upper slice when it is 1. The three low select bits go to both slices. The top level has its own active-high enable and one active-low gate, and both must be asserted for any line to go low.

The logic is purely combinational. It has no clock and no state, so every output follows its inputs in the same cycle.

Top module: `dec4to16_cascade`

## Requirements
- R1: With `ena`=1 and `gate_n`=0, line `out_n[k]` is low exactly when `sel` equals k, with `sel[3]` as the most significant bit. Every other line is high.
- R2: With `ena`=0, all sixteen lines are high for every value of `sel` and `gate_n`.
- R3: With `gate_n`=1, all sixteen lines are high for every value of `sel` and `ena`.
- R4: When `sel[3]`=0, lines `out_n[15:8]` are all high. When `sel[3]`=1, lines `out_n[7:0]` are all high. So at most one slice drives a low line.
- R5: For any input combination, no more than one of the sixteen lines is low.
- R6: When every input is 0 or 1, no output is unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 4 | Value to decode; bit 3 chooses the slice |
| ena | input | 1 | Active-high enable for the whole decoder |
| gate_n | input | 1 | Active-low gate; high forces every line high |
| out_n | output | 16 | One-cold decoded lines, bit k low for value k |

## Verification
The block holds no state, so any fault in the enable wiring or in the minterm logic shows on the ports in the same cycle as the input that exposes it. A slice that stays enabled on the wrong half shows up as two low lines, or as a low line in the half that should be idle. An inverted enable term shows up as low lines while the decoder is disabled. A code bit in the wrong place moves the low line to the wrong index. Every combination of the six inputs is applied, so each of these faults is seen on the first vector that triggers it.

// File: rtl/dec3to8_lowout.sv
module dec3to8_lowout #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0]      code,
  input  logic                   en_hi,
  input  logic                   en_lo_a_n,
  input  logic                   en_lo_b_n,
  output logic [(1<<CODE_W)-1:0] out_n
);
  localparam int LINES = 1 << CODE_W;

  logic live;
  assign live  = en_hi & ~en_lo_a_n & ~en_lo_b_n;
  assign out_n = live ? ~(LINES'(1) << code) : {LINES{1'b1}};
endmodule

// File: rtl/dec4to16_cascade.sv
module dec4to16_cascade (
  input  logic [3:0]  sel,
  input  logic        ena,
  input  logic        gate_n,
  output logic [15:0] out_n
);
  logic ena_n;
  assign ena_n = ~ena;

  dec3to8_lowout #(.CODE_W(3)) u_low (
    .code      (sel[2:0]),
    .en_hi     (ena),
    .en_lo_a_n (sel[3]),
    .en_lo_b_n (gate_n),
    .out_n     (out_n[7:0])
  );

  dec3to8_lowout #(.CODE_W(3)) u_high (
    .code      (sel[2:0]),
    .en_hi     (sel[3]),
    .en_lo_a_n (gate_n),
    .en_lo_b_n (ena_n),
    .out_n     (out_n[15:8])
  );
endmodule

// File: rtl/dec4to16_cascade_chk.sv
module dec4to16_cascade_chk (
  input logic [3:0]  sel,
  input logic        ena,
  input logic        gate_n,
  input logic [15:0] out_n
);
  always_comb begin
    if (!$isunknown({sel, ena, gate_n})) begin
      p_known_r6: assert (!$isunknown(out_n)) else $error("R6 unknown output");
      p_single_low_r5: assert ($onehot0(~out_n)) else $error("R5 more than one low");
      if (ena && !gate_n)
        p_pick_r1: assert ($countones(~out_n) == 1 && out_n[sel] == 1'b0) else $error("R1 wrong line");
      if (!ena)
        p_off_r2: assert (&out_n) else $error("R2 low line while disabled");
      if (gate_n)
        p_gate_r3: assert (&out_n) else $error("R3 low line while gated");
      if (sel[3])
        p_low_idle_r4: assert (&out_n[7:0]) else $error("R4 lower slice active");
      else
        p_high_idle_r4: assert (&out_n[15:8]) else $error("R4 upper slice active");
    end
  end
endmodule

bind dec4to16_cascade dec4to16_cascade_chk u_chk (
  .sel    (sel),
  .ena    (ena),
  .gate_n (gate_n),
  .out_n  (out_n)
);

// File: tb/dec4to16_cascade_tb.sv
module dec4to16_cascade_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  sel;
  logic        ena;
  logic        gate_n;
  logic [15:0] out_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dec4to16_cascade u_dut (.sel(sel), .ena(ena), .gate_n(gate_n), .out_n(out_n));

  localparam logic [21:0] VEC [8] = '{
    {4'd0,  1'b1, 1'b0, 16'hFFFE},
    {4'd7,  1'b1, 1'b0, 16'hFF7F},
    {4'd8,  1'b1, 1'b0, 16'hFEFF},
    {4'd15, 1'b1, 1'b0, 16'h7FFF},
    {4'd10, 1'b1, 1'b0, 16'hFBFF},
    {4'd5,  1'b0, 1'b0, 16'hFFFF},
    {4'd12, 1'b1, 1'b1, 16'hFFFF},
    {4'd3,  1'b0, 1'b1, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d ena=%0b gate_n=%0b actual=%h expected=%h",
               tag, sel, ena, gate_n, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic e, input logic g);
    @(posedge clk);
    sel = s; ena = e; gate_n = g;
    @(negedge clk);
  endtask

  initial begin
    sel = 4'd0; ena = 1'b0; gate_n = 1'b1;
    @(negedge clk);
    check("R2 initial idle", out_n, 16'hFFFF);
    check("R6 initial known", {15'd0, $isunknown(out_n)}, 16'd0);

    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][21:18], VEC[i][17], VEC[i][16]);
      check("R1 table", out_n, VEC[i][15:0]);
    end

    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] exp;
        logic e, g;
        e = m[0]; g = m[1];
        apply(4'(s), e, g);
        exp = (e && !g) ? ~(16'h1 << s) : 16'hFFFF;
        if (e && !g) check("R1 enabled sweep", out_n, exp);
        if (!e)      check("R2 disabled sweep", out_n, 16'hFFFF);
        if (g)       check("R3 gated sweep", out_n, 16'hFFFF);
        if (s >= 8)  check("R4 lower slice idle", {8'hFF, out_n[7:0]}, 16'hFFFF);
        else         check("R4 upper slice idle", {out_n[15:8], 8'hFF}, 16'hFFFF);
        check("R5 at most one low", 16'($countones(~out_n) > 1), 16'd0);
        check("R6 known outputs", {15'd0, $isunknown(out_n)}, 16'd0);
      end
    end

    apply(4'd15, 1'b1, 1'b0);
    apply(4'd0, 1'b1, 1'b0);
    check("R1 wrap from top to bottom line", out_n, 16'hFFFE);
    apply(4'd7, 1'b1, 1'b0);
    apply(4'd8, 1'b1, 1'b0);
    check("R4 slice handover", out_n, 16'hFEFF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule